// File: doc/BRIEF.md
# Byte Read-Modify-Write Sequencer

This block is the execution unit of an 8-bit processor core that handles instructions with a single operand that is read, changed and stored back. There are six operations: increment, decrement, arithmetic shift left, logical shift right, rotate left through carry and rotate right through carry. The operand is one of the accumulator, X or Y registers, a direct-page byte, a direct-page byte indexed by X, or a byte at a 16-bit absolute address. The surrounding core fetches the opcode. It then pulses `start` with the opcode, the address of the byte after the opcode, the current register values and the carry flag.

The sequencer follows a fixed bus schedule for each addressing mode. It fetches operand bytes through a byte-wide bus with a combinational read, computes the result and writes it back to memory or hands it to a register. For one cycle it raises `done`, together with the result and the new N, Z and C flags. An opcode outside the supported set raises `err` for one cycle and causes no bus traffic.

Top module: `byte_rmw_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `bus_rd`, `bus_wr` and `reg_we` are all low.
- R2: Register forms take one idle cycle after `start`. In that cycle `done` is high, exactly one `reg_we` bit is set (bit 0 A, bit 1 X, bit 2 Y) and the bus is not used. Opcodes: 0xBC/0x9C/0x1C/0x5C/0x3C/0x7C are INC/DEC/ASL/LSR/ROL/ROR of A. 0x3D and 0x1D are INC and DEC of X. 0xFC and 0xDC are INC and DEC of Y.
- R3: Direct-page forms (0xAB INC, 0x8B DEC, 0x0B ASL, 0x4B LSR, 0x2B ROL, 0x6B ROR) run three cycles. Cycle 1 reads at `pc` to get the offset. Cycle 2 reads at {`dp_page`, offset}, where `dp_page` forms bit 8 and the bits above it are zero. Cycle 3 writes the result to the same address with `done` high.
- R4: Direct-page-indexed forms (0xBB, 0x9B, 0x1B, 0x5B, 0x3B, 0x7B, in the same operation order as R3) run four cycles. The cycles are: fetch the offset at `pc`, one cycle with no bus access, read at {`dp_page`, (offset+X) mod 256}, and write to that address with `done` high.
- R5: Absolute forms (0xAC, 0x8C, 0x0C, 0x4C, 0x2C, 0x6C, in the same operation order) run four cycles. The cycles are: read the low byte at `pc`, read the high byte at `pc`+1 (wrapping at 16 bits), read at {high, low}, and write there with `done` high.
- R6: INC and DEC produce the result modulo 256. N is result bit 7, Z is set when the result is zero, and `flag_c` equals `c_in`.
- R7: ASL shifts left and brings in 0, with C set to the old bit 7. LSR shifts right and brings in 0, with C set to the old bit 0. N and Z come from the result.
- R8: ROL brings the old carry into bit 0 and sets C to the old bit 7. ROR brings the old carry into bit 7 and sets C to the old bit 0. N and Z come from the result.
- R9: An unsupported opcode on an accepted `start` raises `err` for exactly the next cycle. It produces no bus strobe and no `done`, and the block stays idle.
- R10: A `start` that arrives while `busy` is high is ignored. The running instruction keeps the operands latched at its own start.
- R11: `bus_rd` and `bus_wr` are never high together, and at most one `reg_we` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction when idle |
| opcode | input | 8 | Decoded opcode byte |
| pc | input | 16 | Address of the byte following the opcode |
| dp_page | input | 1 | Direct-page select (bit 8 of direct addresses) |
| a_in | input | 8 | Accumulator value |
| x_in | input | 8 | X register value |
| y_in | input | 8 | Y register value |
| c_in | input | 1 | Carry flag value |
| busy | output | 1 | Instruction in progress |
| err | output | 1 | One-cycle pulse on unsupported opcode |
| done | output | 1 | Final cycle of an instruction |
| reg_we | output | 3 | Register write enable (A, X, Y), valid with done |
| result | output | 8 | Modified operand, valid with done |
| flag_n | output | 1 | New N flag, valid with done |
| flag_z | output | 1 | New Z flag, valid with done |
| flag_c | output | 1 | New C flag, valid with done |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, valid in the same cycle as bus_rd |

## Verification
Random instructions draw from all 28 valid opcodes, with random register values, carry, page select and program counter. Every cycle of each schedule is compared against a model of the per-mode bus timeline, which separates the four addressing modes and catches a swapped operation-to-opcode mapping. Directed cases aim at values where the operations differ: 0x00 and 0xFF at the wrap of increment and decrement, an indexed offset whose sum with X passes 255, a program counter of 0xFFFF so the high-byte fetch wraps, and rotates with both carry values. Unsupported opcodes and a second `start` while busy confirm that the bus stays quiet and that the latched operands do not change.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   typedef enum logic [2:0] {
      OP_INC = 3'd0,
      OP_DEC = 3'd1,
      OP_ASL = 3'd2,
      OP_LSR = 3'd3,
      OP_ROL = 3'd4,
      OP_ROR = 3'd5
   } alu_op_e;

   // Register modes take the values 0..2 so they index reg_we directly.
   typedef enum logic [2:0] {
      M_REG_A = 3'd0,
      M_REG_X = 3'd1,
      M_REG_Y = 3'd2,
      M_DP    = 3'd3,
      M_DPX   = 3'd4,
      M_ABS   = 3'd5
   } amode_e;

   typedef struct packed {
      logic    valid;
      amode_e  mode;
      alu_op_e op;
   } rmw_dec_t;

endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
   import rmw_pkg::*;
(
   input  logic [7:0] opcode,
   output rmw_dec_t   dec
);
   logic [3:0] hi;
   logic [3:0] lo;
   logic       op_ok;
   alu_op_e    hop;

   assign hi = opcode[7:4];
   assign lo = opcode[3:0];

   // The operation follows from the upper three bits of the high nibble.
   always_comb begin
      op_ok = 1'b1;
      hop   = OP_INC;
      unique case (hi[3:1])
         3'd5:    hop = OP_INC;
         3'd4:    hop = OP_DEC;
         3'd0:    hop = OP_ASL;
         3'd2:    hop = OP_LSR;
         3'd1:    hop = OP_ROL;
         3'd3:    hop = OP_ROR;
         default: op_ok = 1'b0;
      endcase
   end

   always_comb begin
      dec = '{valid: 1'b0, mode: M_REG_A, op: OP_INC};
      unique case (lo)
         4'hB: begin
            dec.valid = op_ok;
            dec.mode  = hi[0] ? M_DPX : M_DP;
            dec.op    = hop;
         end
         4'hC: begin
            if (opcode == 8'hFC) begin
               dec = '{valid: 1'b1, mode: M_REG_Y, op: OP_INC};
            end else if (opcode == 8'hDC) begin
               dec = '{valid: 1'b1, mode: M_REG_Y, op: OP_DEC};
            end else begin
               dec.valid = op_ok;
               dec.mode  = hi[0] ? M_REG_A : M_ABS;
               dec.op    = hop;
            end
         end
         4'hD: begin
            if (opcode == 8'h3D)
               dec = '{valid: 1'b1, mode: M_REG_X, op: OP_INC};
            else if (opcode == 8'h1D)
               dec = '{valid: 1'b1, mode: M_REG_X, op: OP_DEC};
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
   import rmw_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] din,
   input  logic              cin,
   output logic [DATA_W-1:0] dout,
   output logic              n,
   output logic              z,
   output logic              cout
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      dout = din;
      cout = cin;
      unique case (op)
         OP_INC: dout = din + {{MSB{1'b0}}, 1'b1};
         OP_DEC: dout = din - {{MSB{1'b0}}, 1'b1};
         OP_ASL: begin dout = {din[MSB-1:0], 1'b0}; cout = din[MSB]; end
         OP_LSR: begin dout = {1'b0, din[MSB:1]};   cout = din[0];   end
         OP_ROL: begin dout = {din[MSB-1:0], cin};  cout = din[MSB]; end
         OP_ROR: begin dout = {cin, din[MSB:1]};    cout = din[0];   end
         default: ;
      endcase
   end

   assign n = dout[MSB];
   assign z = (dout == '0);
endmodule

// File: rtl/rmw_sched.sv
module rmw_sched
   import rmw_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int STEP_W = 3
) (
   input  amode_e            mode,
   input  logic [STEP_W-1:0] step,
   input  logic [ADDR_W-1:0] pc,
   input  logic              page,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] x,
   output logic              rd,
   output logic              wr,
   output logic [ADDR_W-1:0] addr,
   output logic              cap_lo,
   output logic              cap_hi,
   output logic              cap_opnd,
   output logic              last
);
   localparam int PAD = ADDR_W - DATA_W - 1;

   logic [ADDR_W-1:0] dp_ea;
   logic [ADDR_W-1:0] dpx_ea;
   logic [ADDR_W-1:0] abs_ea;
   logic [ADDR_W-1:0] pc_nx;
   logic [DATA_W-1:0] idx_off;

   assign idx_off = lo + x;
   assign dp_ea   = {{PAD{1'b0}}, page, lo};
   assign dpx_ea  = {{PAD{1'b0}}, page, idx_off};
   assign abs_ea  = {hi, lo};
   assign pc_nx   = pc + {{(ADDR_W-1){1'b0}}, 1'b1};

   always_comb begin
      rd       = 1'b0;
      wr       = 1'b0;
      addr     = '0;
      cap_lo   = 1'b0;
      cap_hi   = 1'b0;
      cap_opnd = 1'b0;
      last     = 1'b0;
      if (step != '0) begin
         unique case (mode)
            M_REG_A, M_REG_X, M_REG_Y: last = (step == STEP_W'(1));
            M_DP: begin
               unique case (step)
                  STEP_W'(1): begin rd = 1'b1; addr = pc;    cap_lo = 1'b1;   end
                  STEP_W'(2): begin rd = 1'b1; addr = dp_ea; cap_opnd = 1'b1; end
                  STEP_W'(3): begin wr = 1'b1; addr = dp_ea; last = 1'b1;     end
                  default: ;
               endcase
            end
            M_DPX: begin
               unique case (step)
                  STEP_W'(1): begin rd = 1'b1; addr = pc;     cap_lo = 1'b1;   end
                  STEP_W'(3): begin rd = 1'b1; addr = dpx_ea; cap_opnd = 1'b1; end
                  STEP_W'(4): begin wr = 1'b1; addr = dpx_ea; last = 1'b1;     end
                  default: ;
               endcase
            end
            M_ABS: begin
               unique case (step)
                  STEP_W'(1): begin rd = 1'b1; addr = pc;     cap_lo = 1'b1;   end
                  STEP_W'(2): begin rd = 1'b1; addr = pc_nx;  cap_hi = 1'b1;   end
                  STEP_W'(3): begin rd = 1'b1; addr = abs_ea; cap_opnd = 1'b1; end
                  STEP_W'(4): begin wr = 1'b1; addr = abs_ea; last = 1'b1;     end
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/byte_rmw_seq.sv
module byte_rmw_seq
   import rmw_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [ADDR_W-1:0] pc,
   input  logic              dp_page,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] y_in,
   input  logic              c_in,
   output logic              busy,
   output logic              err,
   output logic              done,
   output logic [2:0]        reg_we,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int STEP_W = 3;
   localparam int NREGS  = 3;

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
      $error("ADDR_W must be twice DATA_W");
   end

   rmw_dec_t          dec;
   logic [STEP_W-1:0] step_q;
   amode_e            mode_q;
   alu_op_e           op_q;
   logic [ADDR_W-1:0] pc_q;
   logic              page_q;
   logic [DATA_W-1:0] x_q;
   logic              c_q;
   logic [DATA_W-1:0] opnd_q;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] hi_q;
   logic              err_q;
   logic              cap_lo;
   logic              cap_hi;
   logic              cap_opnd;
   logic              last;
   logic              accept;
   logic [DATA_W-1:0] reg_src;

   rmw_decode u_dec (.opcode(opcode), .dec(dec));

   rmw_sched #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_sched (
      .mode(mode_q), .step(step_q), .pc(pc_q), .page(page_q),
      .lo(lo_q), .hi(hi_q), .x(x_q),
      .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
      .cap_lo(cap_lo), .cap_hi(cap_hi), .cap_opnd(cap_opnd), .last(last)
   );

   rmw_alu #(.DATA_W(DATA_W)) u_alu (
      .op(op_q), .din(opnd_q), .cin(c_q),
      .dout(result), .n(flag_n), .z(flag_z), .cout(flag_c)
   );

   assign busy      = (step_q != '0);
   assign accept    = start && !busy;
   assign done      = last;
   assign err       = err_q;
   assign bus_wdata = result;

   always_comb begin
      unique case (dec.mode)
         M_REG_X: reg_src = x_in;
         M_REG_Y: reg_src = y_in;
         default: reg_src = a_in;
      endcase
   end

   for (genvar g = 0; g < NREGS; g++) begin : g_we
      assign reg_we[g] = last && (mode_q == amode_e'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= '0;
         mode_q <= M_REG_A;
         op_q   <= OP_INC;
         pc_q   <= '0;
         page_q <= 1'b0;
         x_q    <= '0;
         c_q    <= 1'b0;
         opnd_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (accept) begin
            if (dec.valid) begin
               step_q <= STEP_W'(1);
               mode_q <= dec.mode;
               op_q   <= dec.op;
               pc_q   <= pc;
               page_q <= dp_page;
               x_q    <= x_in;
               c_q    <= c_in;
               opnd_q <= reg_src;
            end else begin
               err_q <= 1'b1;
            end
         end else if (busy) begin
            step_q <= last ? '0 : step_q + STEP_W'(1);
            if (cap_lo)   lo_q   <= bus_rdata;
            if (cap_hi)   hi_q   <= bus_rdata;
            if (cap_opnd) opnd_q <= bus_rdata;
         end
      end
   end
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              err,
   input logic              done,
   input logic [2:0]        reg_we,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr
);
   a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   a_r11_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_we));

   a_r2_we_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we != 3'b000) |-> (done && !bus_rd && !bus_wr));

   a_r3_write_is_last: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> done);

   a_r4_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> (bus_addr == $past(bus_addr) && $past(bus_rd)));

   a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!bus_rd && !bus_wr && !done && !busy));

   a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(start && !busy));

   a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err || $past(start));

   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

bind byte_rmw_seq rmw_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .err(err),
   .done(done), .reg_we(reg_we), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_addr(bus_addr)
);

// File: tb/byte_rmw_seq_test.sv
module byte_rmw_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [15:0] pc = 16'h0000;
   logic        dp_page = 1'b0;
   logic [7:0]  a_in = 8'h00, x_in = 8'h00, y_in = 8'h00;
   logic        c_in = 1'b0;
   logic        busy, err, done, flag_n, flag_z, flag_c, bus_rd, bus_wr;
   logic [2:0]  reg_we;
   logic [7:0]  result, bus_wdata, bus_rdata;
   logic [15:0] bus_addr;
   logic        ovr_en = 1'b0;
   logic [15:0] ovr_addr = 16'h0000;
   logic [7:0]  ovr_data = 8'h00;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   byte_rmw_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc(pc),
      .dp_page(dp_page), .a_in(a_in), .x_in(x_in), .y_in(y_in), .c_in(c_in),
      .busy(busy), .err(err), .done(done), .reg_we(reg_we), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   function automatic logic [7:0] mem_byte(input logic [15:0] ad);
      if (ovr_en && ad == ovr_addr) return ovr_data;
      return ad[7:0] ^ (ad[15:8] * 8'h5B) ^ 8'hA7;
   endfunction

   assign bus_rdata = mem_byte(bus_addr);

   // mode: 0 A,1 X,2 Y,3 DP,4 DPX,5 ABS; op: 0 INC,1 DEC,2 ASL,3 LSR,4 ROL,5 ROR
   function automatic int decode(input logic [7:0] o);
      case (o)
         8'hBC: return 0*8+0; 8'h9C: return 0*8+1; 8'h1C: return 0*8+2;
         8'h5C: return 0*8+3; 8'h3C: return 0*8+4; 8'h7C: return 0*8+5;
         8'h3D: return 1*8+0; 8'h1D: return 1*8+1;
         8'hFC: return 2*8+0; 8'hDC: return 2*8+1;
         8'hAB: return 3*8+0; 8'h8B: return 3*8+1; 8'h0B: return 3*8+2;
         8'h4B: return 3*8+3; 8'h2B: return 3*8+4; 8'h6B: return 3*8+5;
         8'hBB: return 4*8+0; 8'h9B: return 4*8+1; 8'h1B: return 4*8+2;
         8'h5B: return 4*8+3; 8'h3B: return 4*8+4; 8'h7B: return 4*8+5;
         8'hAC: return 5*8+0; 8'h8C: return 5*8+1; 8'h0C: return 5*8+2;
         8'h4C: return 5*8+3; 8'h2C: return 5*8+4; 8'h6C: return 5*8+5;
         default: return -1;
      endcase
   endfunction

   function automatic logic [7:0] opc_at(input int i);
      case (i)
         0: return 8'hBC; 1: return 8'h9C; 2: return 8'h1C; 3: return 8'h5C;
         4: return 8'h3C; 5: return 8'h7C; 6: return 8'h3D; 7: return 8'h1D;
         8: return 8'hFC; 9: return 8'hDC; 10: return 8'hAB; 11: return 8'h8B;
         12: return 8'h0B; 13: return 8'h4B; 14: return 8'h2B; 15: return 8'h6B;
         16: return 8'hBB; 17: return 8'h9B; 18: return 8'h1B; 19: return 8'h5B;
         20: return 8'h3B; 21: return 8'h7B; 22: return 8'hAC; 23: return 8'h8C;
         24: return 8'h0C; 25: return 8'h4C; 26: return 8'h2C; default: return 8'h6C;
      endcase
   endfunction

   // returns {c, result}
   function automatic logic [8:0] model(input int op, input logic [7:0] d, input logic ci);
      case (op)
         0: return {ci, d + 8'd1};
         1: return {ci, d - 8'd1};
         2: return {d[7], d[6:0], 1'b0};
         3: return {d[0], 1'b0, d[7:1]};
         4: return {d[7], d[6:0], ci};
         default: return {d[0], ci, d[7:1]};
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   function automatic string op_req(input int op);
      if (op < 2) return "R6";
      if (op < 4) return "R7";
      return "R8";
   endfunction

   function automatic string mode_req(input int m);
      if (m < 3) return "R2";
      if (m == 3) return "R3";
      if (m == 4) return "R4";
      return "R5";
   endfunction

   task automatic run(input logic [7:0] o, input logic [7:0] a, input logic [7:0] x,
                      input logic [7:0] y, input logic ci, input logic [15:0] p,
                      input logic pg, input bit poke);
      int code, m, op, len;
      logic [7:0] lo, hi, opnd, idx;
      logic [15:0] ea, pc1;
      logic [8:0] r;
      code = decode(o);
      @(negedge clk);
      start = 1'b1; opcode = o; a_in = a; x_in = x; y_in = y; c_in = ci;
      pc = p; dp_page = pg;
      if (code < 0) begin
         @(negedge clk);
         start = 1'b0;
         chk("R9", "err", {15'd0, err}, 16'd1);
         chk("R9", "bus strobes", {14'd0, bus_rd, bus_wr}, 16'd0);
         chk("R9", "done/busy", {14'd0, done, busy}, 16'd0);
         @(negedge clk);
         chk("R9", "err pulse end", {15'd0, err}, 16'd0);
         return;
      end
      m = code / 8; op = code % 8;
      len = (m < 3) ? 1 : (m == 3) ? 3 : 4;
      pc1 = p + 16'd1;
      lo = mem_byte(p);
      hi = mem_byte(pc1);
      idx = lo + x;
      ea = (m == 3) ? {7'd0, pg, lo} : (m == 4) ? {7'd0, pg, idx} : {hi, lo};
      opnd = (m == 0) ? a : (m == 1) ? x : (m == 2) ? y : mem_byte(ea);
      r = model(op, opnd, ci);
      for (int k = 1; k <= len; k++) begin
         bit e_rd, e_wr;
         logic [15:0] e_ad;
         @(negedge clk);
         if (k == 1) begin
            if (poke) begin
               opcode = 8'h00; a_in = ~a; x_in = ~x; y_in = ~y; c_in = ~ci; pc = ~p;
            end else start = 1'b0;
         end
         if (k == 2) start = 1'b0;
         e_rd = 1'b0; e_wr = 1'b0; e_ad = 16'h0000;
         if (m >= 3) begin
            if (k == 1) begin e_rd = 1'b1; e_ad = p; end
            else if (k == len) begin e_wr = 1'b1; e_ad = ea; end
            else if (k == len - 1) begin e_rd = 1'b1; e_ad = ea; end
            else if (m == 5) begin e_rd = 1'b1; e_ad = pc1; end
         end
         chk(mode_req(m), "rd/wr", {14'd0, bus_rd, bus_wr}, {14'd0, e_rd, e_wr});
         if (e_rd || e_wr) chk(mode_req(m), "addr", bus_addr, e_ad);
         chk(poke ? "R10" : mode_req(m), "done", {15'd0, done}, {15'd0, k == len});
         chk("R10", "err", {15'd0, err}, 16'd0);
         if (k == len) begin
            chk(op_req(op), "result", {8'd0, result}, {8'd0, r[7:0]});
            chk(op_req(op), "flags NZC", {13'd0, flag_n, flag_z, flag_c},
                {13'd0, r[7], r[7:0] == 8'd0, r[8]});
            if (e_wr) chk(mode_req(m), "wdata", {8'd0, bus_wdata}, {8'd0, r[7:0]});
            chk("R2", "reg_we", {13'd0, reg_we}, (m < 3) ? (16'd1 << m) : 16'd0);
         end
      end
      @(negedge clk);
      chk("R10", "idle after done", {13'd0, busy, done, err}, 16'd0);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int seed_unused;
      seed_unused = $urandom(32'h1F2E3D4C);
      repeat (3) @(negedge clk);
      chk("R1", "reset outputs", {10'd0, busy, done, err, bus_rd, bus_wr, |reg_we}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle outputs", {11'd0, busy, done, err, bus_rd, bus_wr}, 16'd0);

      // directed corners
      run(8'hBC, 8'hFF, 8'h00, 8'h00, 1'b1, 16'h0200, 1'b0, 0); // R6 inc wrap to zero
      run(8'h1D, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0200, 1'b0, 0); // R6 dec X to FF
      run(8'hDC, 8'h00, 8'h00, 8'h01, 1'b1, 16'h0200, 1'b0, 0); // R6 dec Y to zero
      run(8'h7C, 8'h01, 8'h00, 8'h00, 1'b1, 16'h0200, 1'b0, 0); // R8 ror carry in
      run(8'h3C, 8'h80, 8'h00, 8'h00, 1'b0, 16'h0200, 1'b0, 0); // R8 rol to zero
      run(8'h5C, 8'h01, 8'h00, 8'h00, 1'b0, 16'h0200, 1'b0, 0); // R7 lsr
      run(8'h1C, 8'hC0, 8'h00, 8'h00, 1'b0, 16'h0200, 1'b0, 0); // R7 asl
      ovr_en = 1'b1; ovr_addr = 16'h0000; ovr_data = 8'hF0; // offset F0 at pc 0
      run(8'hBB, 8'h00, 8'h20, 8'h00, 1'b0, 16'h0000, 1'b1, 0); // R4 index wrap
      ovr_en = 1'b0;
      run(8'h6C, 8'h00, 8'h00, 8'h00, 1'b1, 16'hFFFF, 1'b0, 0); // R5 pc+1 wrap
      run(8'h4B, 8'h00, 8'h00, 8'h00, 1'b1, 16'h1234, 1'b1, 0); // R3 page 1
      run(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0300, 1'b0, 0); // R9
      run(8'hCB, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0300, 1'b0, 0); // R9
      run(8'h5D, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0300, 1'b0, 0); // R9
      run(8'hAC, 8'h11, 8'h22, 8'h33, 1'b0, 16'h4000, 1'b0, 1); // R10 start while busy
      run(8'hBC, 8'h11, 8'h22, 8'h33, 1'b0, 16'h4000, 1'b0, 1); // R10

      for (int i = 0; i < 400; i++) begin
         logic [7:0] o;
         if ($urandom % 10 == 0) o = 8'($urandom);
         else o = opc_at(int'($urandom % 28));
         run(o, 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
             16'($urandom), 1'($urandom), ($urandom % 8) == 0);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule